// File: doc/BRIEF.md
# Channel Interrupt Queue with Open-Drain Request

This block gathers interrupt events from a bank of echo canceller channels and presents them to a host processor one at a time. Each event arrives as a one-cycle pulse on that channel's bit of an event vector. The block records the channel number in a first-in first-out queue. While anything is waiting, it pulls an active-low, open-drain interrupt line. The host services the interrupt by reading a result port repeatedly. Each read returns one queued channel number with a valid flag and removes it. The line is released on the read that empties the queue.

Channels are paired into groups: the even channel of group g is the A canceller (channel 2g), and the odd channel is the B canceller (channel 2g+1). A host write to a group's main-control test bits can stand in for a real event, so an interrupt service routine can be exercised without live traffic. This only works when the same write also sets a test-interrupt enable. A channel already waiting in the queue is never entered twice. When the queue has no room, the event is discarded and a sticky overflow flag is raised.

Top module: `chan_irq_fifo`

## Requirements
- R1: After reset, `irq_oe_o` is 0, `ovf_o` is 0, and a read returns `rd_data_o` equal to 0.
- R2: An event pulse on any channel that is not already waiting drives `irq_oe_o` to 1 at the same clock edge that samples the pulse.
- R3: `irq_oe_o` stays 1 while any entry is waiting. It returns to 0 at the edge that samples the read strobe for the last entry.
- R4: A read strobe sampled while entries are waiting removes the oldest entry. In the following cycle, `rd_data_o[5]` (the valid flag) is 1 and `rd_data_o[4:0]` holds the channel number.
- R5: A read strobe sampled while the queue is empty changes nothing. In the following cycle, `rd_data_o` is all zero (valid flag 0).
- R6: Events raised on several channels in the same cycle are queued in ascending channel order.
- R7: An event on a channel that already has an entry waiting adds no entry. Once that entry has been read out, a later event on the channel queues it again.
- R8: A control write with `cfg_tirq_i` = 1 queues channel 2g when `cfg_ta_i` differs from the stored A bit of group g. It queues channel 2g+1 when `cfg_tb_i` differs from the stored B bit.
- R9: A control write with `cfg_tirq_i` = 0, or with both test bits unchanged, queues nothing. It still updates the stored test bits.
- R10: An event that reaches the queue when it is full is discarded. `ovf_o` then becomes 1 and stays 1 until reset.
- R11: Entries queued in different cycles are read out in the order they were queued.
- R12: `irq_do_o` is always 0, so the line is only ever pulled low or left floating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NCH | Per-channel event pulses |
| cfg_wr_i | input | 1 | Main-control write strobe |
| cfg_grp_i | input | GW | Group addressed by the write |
| cfg_tirq_i | input | 1 | Test-interrupt enable carried by the write |
| cfg_ta_i | input | 1 | New A-canceller test bit of the group |
| cfg_tb_i | input | 1 | New B-canceller test bit of the group |
| rd_i | input | 1 | Read strobe for the queue |
| rd_data_o | output | CHW+1 | Read result: valid flag in the top bit, channel number below it |
| irq_oe_o | output | 1 | Open-drain enable: 1 pulls the request line low |
| irq_do_o | output | 1 | Open-drain data value, constant 0 |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A lost or stale bit in the per-channel waiting mask shows up as a missing entry or a duplicate in the read sequence. It surfaces on the very read that should have returned the channel, or on the following empty read. A corrupted queue pointer or count shows as a wrong channel number, or as a valid flag that disagrees with the number of entries outstanding, in the cycle after the strobe. An error in the request logic shows at the edge that samples the first event or the last read: the line either fails to assert or releases while entries remain. Wrong stored test bits appear as an entry that is missing, or one that appears unexpectedly, right after a control write.

// File: rtl/cif_pkg.sv
package cif_pkg;

  // Channel number of the A (is_b = 0) or B (is_b = 1) canceller of a group.
  function automatic int pair_chan(input int grp, input bit is_b);
    return 2 * grp + (is_b ? 1 : 0);
  endfunction

endpackage

// File: rtl/cif_testgen.sv
module cif_testgen #(
  parameter int NCH = 32,
  parameter int GW  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_i,
  input  logic [GW-1:0]  grp_i,
  input  logic           tirq_i,
  input  logic           ta_i,
  input  logic           tb_i,
  output logic [NCH-1:0] tst_o
);
  localparam int NG = NCH / 2;

  logic [NG-1:0] ta_q, tb_q;

  // Stored test bits per group, updated on every write.
  always_ff @(posedge clk) begin
    if (rst) begin
      ta_q <= '0;
      tb_q <= '0;
    end else if (wr_i) begin
      ta_q[grp_i] <= ta_i;
      tb_q[grp_i] <= tb_i;
    end
  end

  // A change of a stored bit becomes a synthetic event when test mode is on.
  always_comb begin
    tst_o = '0;
    if (wr_i && tirq_i) begin
      if (ta_i != ta_q[grp_i]) tst_o[cif_pkg::pair_chan(int'(grp_i), 1'b0)] = 1'b1;
      if (tb_i != tb_q[grp_i]) tst_o[cif_pkg::pair_chan(int'(grp_i), 1'b1)] = 1'b1;
    end
  end

  // R9
  test_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_i |-> (tst_o == '0));

endmodule

// File: rtl/cif_intake.sv
module cif_intake #(
  parameter int NCH = 32,
  parameter int CHW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] evt_i,
  input  logic [NCH-1:0] tst_i,
  input  logic           clr_v_i,
  input  logic [CHW-1:0] clr_chan_i,
  input  logic           space_i,
  output logic           push_o,
  output logic [CHW-1:0] push_chan_o,
  output logic           busy_d_o,
  output logic           ovf_o
);
  // req_q: raised but not yet queued. held_q: raised or queued.
  logic [NCH-1:0] req_q, held_q, req_d, held_d;
  logic [NCH-1:0] clr_oh, held_eff, acc, pick_oh, drop_oh;
  logic           pick_v, ovf_q;
  logic [CHW-1:0] pick_idx;

  always_comb begin
    clr_oh = '0;
    if (clr_v_i) clr_oh[clr_chan_i] = 1'b1;
    held_eff = held_q & ~clr_oh;
    acc      = (evt_i | tst_i) & ~held_eff;

    // Lowest-numbered waiting channel is served first.
    pick_v   = 1'b0;
    pick_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_q[i]) begin
        pick_v   = 1'b1;
        pick_idx = CHW'(i);
      end
    end
    pick_oh = '0;
    if (pick_v) pick_oh[pick_idx] = 1'b1;

    drop_oh = (pick_v && !space_i) ? pick_oh : '0;
    req_d   = (req_q & ~pick_oh) | acc;
    held_d  = (held_eff & ~drop_oh) | acc;
  end

  assign push_o      = pick_v && space_i;
  assign push_chan_o = pick_idx;
  assign busy_d_o    = |req_d;
  assign ovf_o       = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      held_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      req_q  <= req_d;
      held_q <= held_d;
      if (pick_v && !space_i) ovf_q <= 1'b1;
    end
  end

  // R7
  req_held_chk: assert property (@(posedge clk) disable iff (rst)
    push_o |-> held_q[pick_idx]);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);

endmodule

// File: rtl/cif_queue.sv
module cif_queue #(
  parameter int DEPTH = 32,
  parameter int DW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_req_i,
  output logic          space_o,
  output logic          empty_d_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_raw_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop, rd_valid_q;
  logic [DW-1:0] rd_raw_q;

  assign pop       = pop_req_i && (cnt_q != '0);
  assign space_o   = (cnt_q != CW'(DEPTH)) || pop;
  assign cnt_d     = cnt_q + CW'(push_i) - CW'(pop);
  assign empty_d_o = (cnt_d == '0);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage: plain write port plus registered read, suited to block RAM.
  always_ff @(posedge clk) begin
    if (push_i) mem[wptr_q] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (pop) rd_raw_q <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      cnt_q      <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      if (push_i) wptr_q <= step(wptr_q);
      if (pop)    rptr_q <= step(rptr_q);
      cnt_q      <= cnt_d;
      rd_valid_q <= pop;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_raw_o   = rd_raw_q;

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));

  // R4
  pop_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req_i && cnt_q != '0) |=> rd_valid_q);

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req_i && cnt_q == '0) |=> !rd_valid_q);

endmodule

// File: rtl/chan_irq_fifo.sv
module chan_irq_fifo #(
  parameter int NCH   = 32,
  parameter int DEPTH = 32,
  parameter int CHW   = $clog2(NCH),
  parameter int GW    = $clog2(NCH / 2)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] evt_i,
  input  logic           cfg_wr_i,
  input  logic [GW-1:0]  cfg_grp_i,
  input  logic           cfg_tirq_i,
  input  logic           cfg_ta_i,
  input  logic           cfg_tb_i,
  input  logic           rd_i,
  output logic [CHW:0]   rd_data_o,
  output logic           irq_oe_o,
  output logic           irq_do_o,
  output logic           ovf_o
);
  logic [NCH-1:0] tst;
  logic           push, space, busy_d, empty_d, rd_valid;
  logic [CHW-1:0] push_chan, rd_raw;
  logic           irq_q;

  cif_testgen #(.NCH(NCH), .GW(GW)) u_tgen (
    .clk(clk), .rst(rst), .wr_i(cfg_wr_i), .grp_i(cfg_grp_i),
    .tirq_i(cfg_tirq_i), .ta_i(cfg_ta_i), .tb_i(cfg_tb_i), .tst_o(tst)
  );

  cif_intake #(.NCH(NCH), .CHW(CHW)) u_intake (
    .clk(clk), .rst(rst), .evt_i(evt_i), .tst_i(tst),
    .clr_v_i(rd_valid), .clr_chan_i(rd_raw), .space_i(space),
    .push_o(push), .push_chan_o(push_chan), .busy_d_o(busy_d), .ovf_o(ovf_o)
  );

  cif_queue #(.DEPTH(DEPTH), .DW(CHW)) u_queue (
    .clk(clk), .rst(rst), .push_i(push), .din_i(push_chan),
    .pop_req_i(rd_i), .space_o(space), .empty_d_o(empty_d),
    .rd_valid_o(rd_valid), .rd_raw_o(rd_raw)
  );

  // Request is registered from the next-cycle occupancy.
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= busy_d || !empty_d;
  end

  assign irq_oe_o  = irq_q;
  assign irq_do_o  = 1'b0;
  assign rd_data_o = {rd_valid, rd_valid ? rd_raw : {CHW{1'b0}}};

  // R3
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_q) |-> $past(rd_i));

  // R12
  irq_data_chk: assert property (@(posedge clk) disable iff (rst)
    irq_oe_o |-> !irq_do_o);

endmodule

// File: tb/sim_chan_irq_fifo.sv
module sim_chan_irq_fifo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [31:0] evt = '0;
  logic        cwr = 1'b0, ctirq = 1'b0, cta = 1'b0, ctb = 1'b0, rd = 1'b0;
  logic [3:0]  cgrp = '0;
  logic [5:0]  rdata;
  logic        irq_oe, irq_do, ovf;

  logic [7:0]  evt1 = '0;
  logic        rd1 = 1'b0;
  logic [3:0]  rdata1;
  logic        irq1, irqd1, ovf1;

  int tests = 0, fails = 0;
  int exp_q[$];
  logic rd_fire = 1'b0;
  bit done = 0;

  chan_irq_fifo u0 (
    .clk(clk), .rst(rst), .evt_i(evt), .cfg_wr_i(cwr), .cfg_grp_i(cgrp),
    .cfg_tirq_i(ctirq), .cfg_ta_i(cta), .cfg_tb_i(ctb), .rd_i(rd),
    .rd_data_o(rdata), .irq_oe_o(irq_oe), .irq_do_o(irq_do), .ovf_o(ovf)
  );

  chan_irq_fifo #(.NCH(8), .DEPTH(4)) u1 (
    .clk(clk), .rst(rst), .evt_i(evt1), .cfg_wr_i(1'b0), .cfg_grp_i(2'b00),
    .cfg_tirq_i(1'b0), .cfg_ta_i(1'b0), .cfg_tb_i(1'b0), .rd_i(rd1),
    .rd_data_o(rdata1), .irq_oe_o(irq1), .irq_do_o(irqd1), .ovf_o(ovf1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compare each read result against the scoreboard.
  always @(posedge clk) rd_fire <= rd && !rst;
  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        chk(rdata == {1'b1, 5'(e)}, "R4/R11 read entry", rdata, {1'b1, 5'(e)});
      end else begin
        chk(rdata == 6'h00, "R5 empty read", rdata, 0);
      end
    end
  end

  task automatic pulse(input logic [31:0] m);
    @(negedge clk) evt = m;
    @(negedge clk) evt = '0;
  endtask

  task automatic rd_once();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic cwrite(input int g, input bit ti, input bit a, input bit b);
    @(negedge clk) begin cwr = 1'b1; cgrp = 4'(g); ctirq = ti; cta = a; ctb = b; end
    @(negedge clk) cwr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(irq_oe == 1'b0, "R1 irq after reset", irq_oe, 0);
    chk(ovf == 1'b0, "R1 ovf after reset", ovf, 0);
    chk(irq_do == 1'b0, "R12 data value", irq_do, 0);
    rd_once();                                    // R1 / R5: read gives zero
    // R2 single event, R3 release on last read
    pulse(32'h0000_0080);
    exp_q.push_back(7);
    chk(irq_oe == 1'b1, "R2 irq on event", irq_oe, 1);
    idle(3);
    rd_once();
    chk(irq_oe == 1'b0, "R3 release after last read", irq_oe, 0);
    // R6 same-cycle events, ascending order
    pulse(32'h4002_0009);
    exp_q.push_back(0); exp_q.push_back(3); exp_q.push_back(17); exp_q.push_back(30);
    idle(8);
    for (int k = 0; k < 3; k++) begin
      rd_once();
      chk(irq_oe == 1'b1, "R3 held while entries remain", irq_oe, 1);
    end
    rd_once();
    chk(irq_oe == 1'b0, "R3 release on fourth read", irq_oe, 0);
    rd_once();                                    // R5 empty read
    // R7 duplicate suppression, then requeue
    pulse(32'h0000_0200);
    idle(3);
    pulse(32'h0000_0200);
    exp_q.push_back(9);
    idle(3);
    rd_once();
    rd_once();                                    // R7: no second entry
    chk(irq_oe == 1'b0, "R7 no duplicate pending", irq_oe, 0);
    idle(2);
    pulse(32'h0000_0200);
    exp_q.push_back(9);
    chk(irq_oe == 1'b1, "R7 requeue after read", irq_oe, 1);
    idle(2);
    rd_once();
    // R11 order across cycles
    pulse(32'h0010_0000); idle(1);
    pulse(32'h0000_0010); idle(1);
    pulse(32'h0000_0800);
    exp_q.push_back(20); exp_q.push_back(4); exp_q.push_back(11);
    idle(3);
    repeat (3) rd_once();
    // R8 test path: A bit then B bit of group 5
    cwrite(5, 1'b1, 1'b1, 1'b0);
    exp_q.push_back(10);
    chk(irq_oe == 1'b1, "R8 test entry raises irq", irq_oe, 1);
    cwrite(5, 1'b1, 1'b1, 1'b1);
    exp_q.push_back(11);
    idle(3);
    rd_once(); rd_once();
    chk(irq_oe == 1'b0, "R8 drained", irq_oe, 0);
    // R9 test bits change with test mode off, then no change with it on
    cwrite(5, 1'b0, 1'b0, 1'b0);
    idle(3);
    chk(irq_oe == 1'b0, "R9 disabled write quiet", irq_oe, 0);
    cwrite(5, 1'b1, 1'b0, 1'b0);
    idle(3);
    chk(irq_oe == 1'b0, "R9 unchanged bits quiet", irq_oe, 0);
    rd_once();                                    // R9: queue empty
    chk(ovf == 1'b0, "R10 no overflow at full depth", ovf, 0);
    // R10 overflow on the small instance (depth 4, 8 channels)
    @(negedge clk) evt1 = 8'hFF;
    @(negedge clk) evt1 = 8'h00;
    idle(12);
    chk(ovf1 == 1'b1, "R10 overflow set", ovf1, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) rd1 = 1'b1;
      @(negedge clk) rd1 = 1'b0;
      chk(rdata1 == {1'b1, 3'(k)}, "R10 kept entries", rdata1, {1'b1, 3'(k)});
    end
    @(negedge clk) rd1 = 1'b1;
    @(negedge clk) rd1 = 1'b0;
    chk(rdata1 == 4'h0, "R10 dropped entries absent", rdata1, 0);
    chk(ovf1 == 1'b1, "R10 overflow sticky", ovf1, 1);
    chk(irq1 == 1'b0 && irqd1 == 1'b0, "R12 small instance released", irq1, 0);
    idle(2);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule